// File: doc/BRIEF.md
# Single-Operand ALU Flag Unit

This block is a datapath slice that takes one destination operand (and, for the logical family, a source operand) and produces a 16-bit result and new N, Z, V and C condition flags. It covers the minicomputer-style single-operand group and the logical moves: clear, complement, increment, decrement, negate, add carry, subtract carry, the rotates, the arithmetic shifts, byte swap, sign extend, bit clear, bit set, exclusive or and move. Each operation follows its own flag rules rather than one shared adder flag set.

The caller presents the operands, an operation code, a byte-mode flag and the current flags, then pulses `start`. One cycle later the result and flags are registered and `flags_valid` pulses. One cycle after that, `wr_stb` pulses to issue the destination write. Because the flags are committed a cycle before the write is issued, a fault on that write cannot leave stale flags. Operand fetch, addressing and memory lie outside the block.

In byte mode only the low byte is operated on. The high byte of the result is copied from the destination operand, N comes from bit 7 and Z looks only at the low byte.

Top module: `sop_flag_unit`

## Requirements
- R1: After reset, `result`, the four flags, `flags_valid` and `wr_stb` are all 0. When `start` is high at a clock edge, the result and flags are registered at that edge and `flags_valid` is high for exactly the following cycle. `wr_stb` is high for exactly the cycle after that.
- R2: Clear (op 0) yields 0 and flags N=0, Z=1, V=0, C=0.
- R3: Complement (op 1) yields the bitwise inverse. C is set to 1, V to 0, and N and Z are taken from the result.
- R4: Increment (op 2) and decrement (op 3) leave C unchanged. V is set only when an increment gives the most negative value (0x8000, or 0x80 in byte mode) or when a decrement gives the most positive value (0x7FFF, or 0x7F).
- R5: Negate (op 4) yields the two's complement. V is set only when the result is the most negative value, and C equals NOT Z.
- R6: Add-carry (op 5) adds the incoming C. V = C AND (result is the most negative value), and the new C = old C AND (result is zero). Subtract-carry (op 6) subtracts the incoming C. V is set when the result is the most negative value, and the new C = old C AND (operand was zero).
- R7: Rotate right (op 7) and rotate left (op 8) shift the old C into the vacated end and load C with the bit shifted out. V = N XOR C.
- R8: Arithmetic shift right (op 9) keeps the sign bit. Arithmetic shift left (op 10) fills with 0. Both load C with the bit shifted out and set V = N XOR C.
- R9: Byte swap (op 11) exchanges the two bytes and clears V and C. N is bit 7 of the result and Z tests only its low byte. It ignores byte mode.
- R10: Sign extend (op 12) writes all ones when the incoming N is 1 and zero otherwise. It sets Z = NOT N, clears V, leaves C unchanged and ignores byte mode.
- R11: Bit clear (op 13: dst AND NOT src), bit set (op 14: dst OR src), exclusive or (op 15: dst XOR src) and move (op 16: src) take N and Z from the result, clear V and leave C unchanged.
- R12: With `byte_mode` high, every operation other than ops 11 and 12 acts on the low byte only. `result[15:8]` equals `dst_val[15:8]`, N is bit 7 and Z tests bits 7:0.
- R13: Op codes 17 to 31 are reserved. They return `dst_val` unchanged with all four flags equal to `flags_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation on the inputs present at this edge |
| op | input | 5 | Operation code (see requirements) |
| byte_mode | input | 1 | Operate on the low byte only |
| dst_val | input | 16 | Destination operand |
| src_val | input | 16 | Source operand for ops 13 to 16 |
| flags_in | input | 4 | Current flags {N,Z,V,C} |
| result | output | 16 | Registered result |
| n_flag | output | 1 | New N |
| z_flag | output | 1 | New Z |
| v_flag | output | 1 | New V |
| c_flag | output | 1 | New C |
| flags_valid | output | 1 | One-cycle pulse: result and flags are updated |
| wr_stb | output | 1 | One-cycle pulse, one cycle after flags_valid: issue destination write |

## Verification
The assertions take for granted that `op`, `byte_mode`, the operands and `flags_in` are defined (free of X) whenever `start` is high, because the checker compares outputs against the `$past` values of those inputs. The directed stimulus drives every input to a known value on the falling edge before each start pulse and holds it through the sampling edge. It leaves `start` low between operations, so each flag check refers to a single operation.

// File: rtl/sop_flag_unit.sv
module sop_flag_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [4:0]   op,
  input  logic         byte_mode,
  input  logic [W-1:0] dst_val,
  input  logic [W-1:0] src_val,
  input  logic [3:0]   flags_in,
  output logic [W-1:0] result,
  output logic         n_flag,
  output logic         z_flag,
  output logic         v_flag,
  output logic         c_flag,
  output logic         flags_valid,
  output logic         wr_stb
);
  localparam int B = W / 2;
  localparam logic [4:0] OP_CLR = 5'd0,  OP_COM = 5'd1,  OP_INC = 5'd2,  OP_DEC = 5'd3,
                         OP_NEG = 5'd4,  OP_ADC = 5'd5,  OP_SBC = 5'd6,  OP_ROR = 5'd7,
                         OP_ROL = 5'd8,  OP_ASR = 5'd9,  OP_ASL = 5'd10, OP_SWB = 5'd11,
                         OP_SXT = 5'd12, OP_BIC = 5'd13, OP_BIS = 5'd14, OP_XOR = 5'd15,
                         OP_MOV = 5'd16;
  localparam logic [W-1:0] W_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic [B-1:0] B_MIN = {1'b1, {(B-1){1'b0}}};

  logic         ci, ni, lane_b, shout, msb_a;
  logic [W-1:0] r, res_d;
  logic         rn, rz, at_min, at_max;
  logic [3:0]   f_d;

  assign ci     = flags_in[0];
  assign ni     = flags_in[3];
  assign lane_b = byte_mode && op != OP_SWB && op != OP_SXT;
  assign msb_a  = lane_b ? dst_val[B-1] : dst_val[W-1];

  always_comb begin
    r     = dst_val;
    shout = 1'b0;
    case (op)
      OP_CLR: r = '0;
      OP_COM: r = ~dst_val;
      OP_INC: r = dst_val + 1'b1;
      OP_DEC: r = dst_val - 1'b1;
      OP_NEG: r = ~dst_val + 1'b1;
      OP_ADC: r = dst_val + {{(W-1){1'b0}}, ci};
      OP_SBC: r = dst_val - {{(W-1){1'b0}}, ci};
      OP_ROR: begin
        r = lane_b ? {{B{1'b0}}, ci, dst_val[B-1:1]} : {ci, dst_val[W-1:1]};
        shout = dst_val[0];
      end
      OP_ROL: begin
        r = {dst_val[W-2:0], ci};
        shout = msb_a;
      end
      OP_ASR: begin
        r = lane_b ? {{B{1'b0}}, dst_val[B-1], dst_val[B-1:1]} : {dst_val[W-1], dst_val[W-1:1]};
        shout = dst_val[0];
      end
      OP_ASL: begin
        r = {dst_val[W-2:0], 1'b0};
        shout = msb_a;
      end
      OP_SWB: r = {dst_val[B-1:0], dst_val[W-1:B]};
      OP_SXT: r = {W{ni}};
      OP_BIC: r = dst_val & ~src_val;
      OP_BIS: r = dst_val | src_val;
      OP_XOR: r = dst_val ^ src_val;
      OP_MOV: r = src_val;
      default: r = dst_val;
    endcase
  end

  assign res_d  = lane_b ? {dst_val[W-1:B], r[B-1:0]} : r;
  assign rn     = (lane_b || op == OP_SWB) ? r[B-1] : r[W-1];
  assign rz     = (lane_b || op == OP_SWB) ? (r[B-1:0] == '0) : (r == '0);
  assign at_min = lane_b ? (r[B-1:0] == B_MIN) : (r == W_MIN);
  assign at_max = lane_b ? (r[B-1:0] == ~B_MIN) : (r == ~W_MIN);

  always_comb begin
    case (op)
      OP_CLR:                         f_d = 4'b0100;
      OP_COM:                         f_d = {rn, rz, 1'b0, 1'b1};
      OP_INC:                         f_d = {rn, rz, at_min, ci};
      OP_DEC:                         f_d = {rn, rz, at_max, ci};
      OP_NEG:                         f_d = {rn, rz, at_min, !rz};
      OP_ADC:                         f_d = {rn, rz, at_min & ci, rz & ci};
      OP_SBC:                         f_d = {rn, rz, at_min,
                                             ci & (lane_b ? dst_val[B-1:0] == '0 : dst_val == '0)};
      OP_ROR, OP_ROL, OP_ASR, OP_ASL: f_d = {rn, rz, rn ^ shout, shout};
      OP_SWB:                         f_d = {rn, rz, 2'b00};
      OP_SXT:                         f_d = {ni, !ni, 1'b0, ci};
      OP_BIC, OP_BIS, OP_XOR, OP_MOV: f_d = {rn, rz, 1'b0, ci};
      default:                        f_d = flags_in;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result <= '0;
      {n_flag, z_flag, v_flag, c_flag} <= '0;
      flags_valid <= 1'b0;
      wr_stb <= 1'b0;
    end else begin
      flags_valid <= start;
      wr_stb <= flags_valid;
      if (start) begin
        result <= res_d;
        {n_flag, z_flag, v_flag, c_flag} <= f_d;
      end
    end
  end
endmodule

module sop_flag_unit_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [4:0]   op,
  input logic         byte_mode,
  input logic [W-1:0] dst_val,
  input logic [W-1:0] src_val,
  input logic [3:0]   flags_in,
  input logic [W-1:0] result,
  input logic         n_flag,
  input logic         z_flag,
  input logic         v_flag,
  input logic         c_flag,
  input logic         flags_valid,
  input logic         wr_stb
);
  localparam int B = W / 2;

  a_r1_write_after_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(flags_valid));
  a_r1_valid_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
    flags_valid |-> $past(start));
  a_r2_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_valid && $past(op) == 5'd0) |-> ({n_flag, z_flag, v_flag, c_flag} == 4'b0100));
  a_r3_complement_cv: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_valid && $past(op) == 5'd1) |-> (c_flag && !v_flag));
  a_r7_shift_v_rule: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_valid && $past(op) >= 5'd7 && $past(op) <= 5'd10) |-> (v_flag == (n_flag ^ c_flag)));
  a_r11_logic_keeps_c: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_valid && $past(op) >= 5'd13 && $past(op) <= 5'd16) |-> (c_flag == $past(flags_in[0]) && !v_flag));
  a_r12_high_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_valid && $past(byte_mode) && $past(op) != 5'd11 && $past(op) != 5'd12)
      |-> (result[W-1:B] == $past(dst_val[W-1:B])));
  a_r13_reserved_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_valid && $past(op) >= 5'd17 && !$past(byte_mode))
      |-> (result == $past(dst_val) && {n_flag, z_flag, v_flag, c_flag} == $past(flags_in)));
endmodule

bind sop_flag_unit sop_flag_unit_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .byte_mode(byte_mode),
  .dst_val(dst_val), .src_val(src_val), .flags_in(flags_in), .result(result),
  .n_flag(n_flag), .z_flag(z_flag), .v_flag(v_flag), .c_flag(c_flag),
  .flags_valid(flags_valid), .wr_stb(wr_stb)
);

// File: tb/sop_flag_unit_tb.sv
module sop_flag_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  op = '0;
  logic        byte_mode = 1'b0;
  logic [15:0] dst_val = '0, src_val = '0;
  logic [3:0]  flags_in = '0;
  logic [15:0] result;
  logic        n_flag, z_flag, v_flag, c_flag, flags_valid, wr_stb;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sop_flag_unit #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .byte_mode(byte_mode),
    .dst_val(dst_val), .src_val(src_val), .flags_in(flags_in), .result(result),
    .n_flag(n_flag), .z_flag(z_flag), .v_flag(v_flag), .c_flag(c_flag),
    .flags_valid(flags_valid), .wr_stb(wr_stb)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic go(input string tag, input logic [4:0] o, input logic bm,
                    input logic [15:0] d, input logic [15:0] s, input logic [3:0] fi,
                    input logic [15:0] er, input logic [3:0] ef);
    @(negedge clk);
    op = o; byte_mode = bm; dst_val = d; src_val = s; flags_in = fi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " result"}, {16'h0, result}, {16'h0, er});
    check({tag, " flags"}, {28'h0, n_flag, z_flag, v_flag, c_flag}, {28'h0, ef});
    check("R1 flags_valid pulse", {31'h0, flags_valid & ~wr_stb}, 32'h1);
    @(negedge clk);
    check("R1 wr_stb after flags", {30'h0, wr_stb, flags_valid}, 32'h2);
  endtask

  task automatic t_reset();
    check("R1 reset outputs", {result, 12'h0, n_flag, z_flag, v_flag, c_flag},
          32'h0);
    check("R1 reset strobes", {30'h0, flags_valid, wr_stb}, 32'h0);
  endtask

  task automatic t_clear_complement();
    go("R2 clear", 5'd0, 1'b0, 16'h1234, 16'h0, 4'b1011, 16'h0000, 4'b0100);
    go("R3 complement", 5'd1, 1'b0, 16'h0000, 16'h0, 4'b0000, 16'hFFFF, 4'b1001);
  endtask

  task automatic t_inc_dec_neg();
    go("R4 inc to min", 5'd2, 1'b0, 16'h7FFF, 16'h0, 4'b0001, 16'h8000, 4'b1011);
    go("R4 dec to max", 5'd3, 1'b0, 16'h8000, 16'h0, 4'b0000, 16'h7FFF, 4'b0010);
    go("R5 neg zero", 5'd4, 1'b0, 16'h0000, 16'h0, 4'b0000, 16'h0000, 4'b0100);
    go("R5 neg min", 5'd4, 1'b0, 16'h8000, 16'h0, 4'b0000, 16'h8000, 4'b1011);
    go("R5 neg one", 5'd4, 1'b0, 16'h0001, 16'h0, 4'b0000, 16'hFFFF, 4'b1001);
  endtask

  task automatic t_carry_ops();
    go("R6 adc wrap", 5'd5, 1'b0, 16'hFFFF, 16'h0, 4'b0001, 16'h0000, 4'b0101);
    go("R6 adc to min", 5'd5, 1'b0, 16'h7FFF, 16'h0, 4'b0001, 16'h8000, 4'b1010);
    go("R6 sbc from zero", 5'd6, 1'b0, 16'h0000, 16'h0, 4'b0001, 16'hFFFF, 4'b1001);
    go("R6 sbc to min", 5'd6, 1'b0, 16'h8001, 16'h0, 4'b0001, 16'h8000, 4'b1010);
  endtask

  task automatic t_shifts();
    go("R7 ror", 5'd7, 1'b0, 16'h0001, 16'h0, 4'b0001, 16'h8000, 4'b1001);
    go("R7 rol", 5'd8, 1'b0, 16'h8000, 16'h0, 4'b0000, 16'h0000, 4'b0111);
    go("R8 asr", 5'd9, 1'b0, 16'h8001, 16'h0, 4'b0000, 16'hC000, 4'b1001);
    go("R8 asl", 5'd10, 1'b0, 16'h4000, 16'h0, 4'b0000, 16'h8000, 4'b1010);
  endtask

  task automatic t_swap_sxt();
    go("R9 swab", 5'd11, 1'b0, 16'h1280, 16'h0, 4'b0011, 16'h8012, 4'b0000);
    go("R9 swab low zero", 5'd11, 1'b0, 16'h00FF, 16'h0, 4'b0000, 16'hFF00, 4'b0100);
    go("R9 swab ignores byte", 5'd11, 1'b1, 16'h8000, 16'h0, 4'b0000, 16'h0080, 4'b1000);
    go("R10 sxt neg", 5'd12, 1'b0, 16'h1234, 16'h0, 4'b1001, 16'hFFFF, 4'b1001);
    go("R10 sxt pos", 5'd12, 1'b1, 16'h1234, 16'h0, 4'b0110, 16'h0000, 4'b0100);
  endtask

  task automatic t_logic();
    go("R11 bic", 5'd13, 1'b0, 16'hFFFF, 16'h00FF, 4'b0011, 16'hFF00, 4'b1001);
    go("R11 bis", 5'd14, 1'b0, 16'h0000, 16'h0000, 4'b1010, 16'h0000, 4'b0100);
    go("R11 xor", 5'd15, 1'b0, 16'hAAAA, 16'hAAAA, 4'b0001, 16'h0000, 4'b0101);
    go("R11 mov", 5'd16, 1'b0, 16'h1111, 16'h8000, 4'b0000, 16'h8000, 4'b1000);
  endtask

  task automatic t_byte();
    go("R12 R4 incb", 5'd2, 1'b1, 16'hAB7F, 16'h0, 4'b0000, 16'hAB80, 4'b1010);
    go("R12 R8 asrb", 5'd9, 1'b1, 16'h1281, 16'h0, 4'b0000, 16'h12C0, 4'b1001);
    go("R12 R7 rolb", 5'd8, 1'b1, 16'hFF80, 16'h0, 4'b0001, 16'hFF01, 4'b0011);
    go("R12 movb", 5'd16, 1'b1, 16'h1234, 16'h5680, 4'b0000, 16'h1280, 4'b1000);
    go("R12 clrb", 5'd0, 1'b1, 16'hABCD, 16'h0, 4'b1111, 16'hAB00, 4'b0100);
  endtask

  task automatic t_reserved();
    go("R13 reserved", 5'd20, 1'b0, 16'h5555, 16'h1234, 4'b1010, 16'h5555, 4'b1010);
    go("R13 reserved top", 5'd31, 1'b0, 16'h0F0F, 16'h0, 4'b0101, 16'h0F0F, 4'b0101);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_clear_complement();
    t_inc_dec_neg();
    t_carry_ops();
    t_shifts();
    t_swap_sxt();
    t_logic();
    t_byte();
    t_reserved();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL R1 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule